// File: doc/BRIEF.md
# Load/Store Sub-Word Alignment Unit

This unit sits on the data side between a 32-bit integer core and a data memory one word wide. For every memory request it adds the base register value to the 16-bit instruction offset, after sign-extending the offset, to form the effective address. It presents the word-aligned address to memory, and it rejects halfword or word requests whose effective address is not naturally aligned.

For stores it builds a 4-bit byte-lane write-enable mask and a write word. In that word the source value is repeated across every lane of the access width, so the mask alone decides which lanes memory updates. For loads it remembers the access shape for one cycle. When the memory word returns on the following cycle, it picks out the addressed byte or halfword and widens it to 32 bits with either sign or zero fill.

A mode input chooses how byte addresses map onto lanes. In little-endian mode the byte at the lowest address of a word occupies bits [7:0]. In big-endian mode it occupies bits [31:24].

Top module: `lsu_subword_align`

## Requirements
- R1: The effective address is `base_val + sign_extend(offset)` modulo 2^32, and `mem_addr` carries that address with bits [1:0] cleared.
- R2: With `req_size` encoded 00 byte, 01 halfword, 1x word, `misalign` is high for a valid halfword request with address bit 0 set or a valid word request with address bits [1:0] nonzero, and is low otherwise.
- R3: While `misalign` is high, `mem_req` is low, `mem_be` is 0000, and no load response appears on the next cycle.
- R4: In little-endian mode (`big_endian`=0) a byte store enables lane a[1:0], a halfword store enables lanes {a[1]*2+1, a[1]*2}, and a word store enables all four lanes. Lane k is `mem_wdata[8k+7:8k]`.
- R5: In big-endian mode a byte store enables lane 3-a[1:0], and a halfword store enables lanes 3:2 when a[1]=0 and lanes 1:0 when a[1]=1.
- R6: Store write data is the low byte of `store_val` in all four lanes for byte stores, the low halfword in both halves for halfword stores, and `store_val` unchanged for word stores. `mem_we` is high only for accepted stores, and loads drive `mem_be` to 0000.
- R7: An accepted load raises `ld_valid` exactly one cycle later, with `ld_data` formed from `mem_rdata` of that cycle. `ld_valid` is low in every other cycle and while reset is held.
- R8: A byte load returns the addressed lane sign-extended when `req_unsigned`=0 and zero-extended when `req_unsigned`=1.
- R9: A halfword load returns the addressed halfword, assembled most significant byte first per the endian mode, sign- or zero-extended per `req_unsigned`.
- R10: A word load returns `mem_rdata` unchanged, and `req_unsigned` has no effect on it.
- R11: The lane mapping applied to a load's response is the one selected by `big_endian` in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 1x word |
| req_unsigned | input | 1 | Zero-extend sub-word loads |
| big_endian | input | 1 | Lane mapping mode |
| base_val | input | 32 | Base register value |
| offset | input | 16 | Signed instruction offset |
| store_val | input | 32 | Store source register value |
| mem_rdata | input | 32 | Word returned by memory one cycle after a read |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Byte-lane write enables |
| mem_wdata | output | 32 | Lane-replicated write data |
| misalign | output | 1 | Misaligned-access exception |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |

## Verification
The response of a load issued in cycle N is delivered in cycle N+1. In that same cycle the new request goes through address generation, store-lane building or a misalignment check. Only the held load context and the live request path must stay apart. The bench provokes this by issuing requests back to back: a misaligned request directly after a load, a store directly after a load, and loads in opposite endian modes one after another. A behavioural byte-address model checks, every cycle, both the delayed result of the earlier load and the request-side outputs of the new one.

// File: rtl/lsu_align_pkg.sv
`timescale 1ns/1ps
package lsu_align_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  // 00 byte, 01 half, 1x word
  function automatic acc_size_e decode_size(input logic [1:0] raw);
    if (raw[1])      return SZ_WORD;
    else if (raw[0]) return SZ_HALF;
    else             return SZ_BYTE;
  endfunction

endpackage

// File: rtl/lsu_agu.sv
`timescale 1ns/1ps
// Effective address, aligned word address, starting lane and alignment check.
module lsu_agu
  import lsu_align_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int OFFW = 16,
  localparam int LANES = XLEN / 8,
  localparam int LANE_BITS = $clog2(LANES)
) (
  input  logic [XLEN-1:0]      base_val,
  input  logic [OFFW-1:0]      offset,
  input  acc_size_e            size,
  input  logic                 big_endian,
  output logic [XLEN-1:0]      word_addr,
  output logic [LANE_BITS-1:0] lane,
  output logic                 unaligned
);

  logic [XLEN-1:0]      ea;
  logic [LANE_BITS-1:0] a_lo;
  logic [LANE_BITS-1:0] half_lo;

  always_comb begin
    ea        = base_val + {{(XLEN-OFFW){offset[OFFW-1]}}, offset};
    a_lo      = ea[LANE_BITS-1:0];
    word_addr = {ea[XLEN-1:LANE_BITS], {LANE_BITS{1'b0}}};
    half_lo   = {a_lo[LANE_BITS-1:1], 1'b0};

    // lane holds the lowest lane of the accessed field
    unique case (size)
      SZ_BYTE: lane = big_endian ? (LANE_BITS'(LANES-1) - a_lo) : a_lo;
      SZ_HALF: lane = big_endian ? (LANE_BITS'(LANES-2) - half_lo) : half_lo;
      default: lane = '0;
    endcase

    unique case (size)
      SZ_BYTE: unaligned = 1'b0;
      SZ_HALF: unaligned = a_lo[0];
      default: unaligned = |a_lo;
    endcase
  end

endmodule

// File: rtl/lsu_store_lanes.sv
`timescale 1ns/1ps
// Byte-lane enables and replicated write data for stores.
module lsu_store_lanes
  import lsu_align_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int LANES = XLEN / 8,
  localparam int LANE_BITS = $clog2(LANES)
) (
  input  logic                 store_en,
  input  acc_size_e            size,
  input  logic [LANE_BITS-1:0] lane,
  input  logic [XLEN-1:0]      src,
  output logic [LANES-1:0]     be,
  output logic [XLEN-1:0]      wdata
);

  logic [XLEN-1:0] byte_rep;
  logic [XLEN-1:0] half_rep;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign byte_rep[g*8 +: 8] = src[7:0];
    assign half_rep[g*8 +: 8] = src[(g % 2)*8 +: 8];

    always_comb begin
      unique case (size)
        SZ_BYTE: be[g] = store_en && (lane == LANE_BITS'(g));
        SZ_HALF: be[g] = store_en && (lane[LANE_BITS-1:1] == LANE_BITS'(g) >> 1);
        default: be[g] = store_en;
      endcase
    end
  end

  always_comb begin
    unique case (size)
      SZ_BYTE: wdata = byte_rep;
      SZ_HALF: wdata = half_rep;
      default: wdata = src;
    endcase
  end

endmodule

// File: rtl/lsu_load_extract.sv
`timescale 1ns/1ps
// Lane selection and sign/zero extension of a returned word.
module lsu_load_extract
  import lsu_align_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int LANES = XLEN / 8,
  localparam int LANE_BITS = $clog2(LANES)
) (
  input  acc_size_e            size,
  input  logic [LANE_BITS-1:0] lane,
  input  logic                 is_unsigned,
  input  logic [XLEN-1:0]      rdata,
  output logic [XLEN-1:0]      data
);

  logic [7:0]  sel_b;
  logic [15:0] sel_h;
  logic        fill;

  always_comb begin
    sel_b = rdata[{lane, 3'b000} +: 8];
    sel_h = rdata[{lane, 3'b000} +: 16];
    fill  = 1'b0;
    unique case (size)
      SZ_BYTE: begin
        fill = !is_unsigned && sel_b[7];
        data = {{(XLEN-8){fill}}, sel_b};
      end
      SZ_HALF: begin
        fill = !is_unsigned && sel_h[15];
        data = {{(XLEN-16){fill}}, sel_h};
      end
      default: data = rdata;
    endcase
  end

endmodule

// File: rtl/lsu_subword_align.sv
`timescale 1ns/1ps
// Top: request-side address and lane logic, plus a one-cycle load context
// register aligning the returned word. rst_n is expected to be deasserted
// synchronously to clk by the reset tree.
module lsu_subword_align
  import lsu_align_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int OFFW = 16,
  localparam int LANES = XLEN / 8,
  localparam int LANE_BITS = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_store,
  input  logic [1:0]       req_size,
  input  logic             req_unsigned,
  input  logic             big_endian,
  input  logic [XLEN-1:0]  base_val,
  input  logic [OFFW-1:0]  offset,
  input  logic [XLEN-1:0]  store_val,
  input  logic [XLEN-1:0]  mem_rdata,
  output logic             mem_req,
  output logic             mem_we,
  output logic [XLEN-1:0]  mem_addr,
  output logic [LANES-1:0] mem_be,
  output logic [XLEN-1:0]  mem_wdata,
  output logic             misalign,
  output logic             ld_valid,
  output logic [XLEN-1:0]  ld_data
);

  typedef struct packed {
    acc_size_e            size;
    logic [LANE_BITS-1:0] lane;
    logic                 is_unsigned;
  } ld_ctx_t;

  acc_size_e            size;
  logic [LANE_BITS-1:0] lane;
  logic                 unaligned;
  logic                 accept;
  logic                 ld_accept;

  ld_ctx_t ctx_d, ctx_q;
  logic    ld_valid_d, ld_valid_q;

  assign size = decode_size(req_size);

  lsu_agu #(.XLEN(XLEN), .OFFW(OFFW)) u_agu (
    .base_val   (base_val),
    .offset     (offset),
    .size       (size),
    .big_endian (big_endian),
    .word_addr  (mem_addr),
    .lane       (lane),
    .unaligned  (unaligned)
  );

  always_comb begin
    misalign  = req_valid && unaligned;
    accept    = req_valid && !unaligned;
    ld_accept = accept && !req_store;
    mem_req   = accept;
    mem_we    = accept && req_store;
  end

  lsu_store_lanes #(.XLEN(XLEN)) u_store (
    .store_en (mem_we),
    .size     (size),
    .lane     (lane),
    .src      (store_val),
    .be       (mem_be),
    .wdata    (mem_wdata)
  );

  // next-state
  always_comb begin
    ld_valid_d = ld_accept;
    ctx_d      = ctx_q;
    if (ld_accept) begin
      ctx_d.size        = size;
      ctx_d.lane        = lane;
      ctx_d.is_unsigned = req_unsigned;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ld_valid_q <= 1'b0;
    else        ld_valid_q <= ld_valid_d;
  end

  always_ff @(posedge clk) begin
    if (ld_accept) ctx_q <= ctx_d;
  end

  assign ld_valid = ld_valid_q;

  lsu_load_extract #(.XLEN(XLEN)) u_extract (
    .size        (ctx_q.size),
    .lane        (ctx_q.lane),
    .is_unsigned (ctx_q.is_unsigned),
    .rdata       (mem_rdata),
    .data        (ld_data)
  );

endmodule

// File: rtl/lsu_subword_align_chk.sv
`timescale 1ns/1ps
module lsu_subword_align_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_store,
  input logic [1:0]  req_size,
  input logic        req_unsigned,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [3:0]  mem_be,
  input logic        misalign,
  input logic        ld_valid,
  input logic [31:0] ld_data
);

  assert_addr_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);

  assert_misalign_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (!mem_req && mem_be == 4'b0000));

  assert_no_resp_after_misalign_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (misalign && !mem_req) |=> !ld_valid);

  assert_byte_store_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && req_size == 2'b00) |-> $countones(mem_be) == 1);

  assert_half_store_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && req_size == 2'b01) |-> (mem_be == 4'b0011 || mem_be == 4'b1100));

  assert_load_no_be_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> mem_be == 4'b0000);

  assert_resp_follows_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && !req_store) |=> ld_valid);

  assert_resp_only_after_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && !mem_we) |=> !ld_valid);

  assert_lbu_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && req_size == 2'b00 && req_unsigned) |=> ld_data[31:8] == 24'h0);

  assert_lhu_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && req_size == 2'b01 && req_unsigned) |=> ld_data[31:16] == 16'h0);

endmodule

bind lsu_subword_align lsu_subword_align_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_store    (req_store),
  .req_size     (req_size),
  .req_unsigned (req_unsigned),
  .mem_req      (mem_req),
  .mem_we       (mem_we),
  .mem_addr     (mem_addr),
  .mem_be       (mem_be),
  .misalign     (misalign),
  .ld_valid     (ld_valid),
  .ld_data      (ld_data)
);

// File: tb/tb_lsu_subword_align.sv
`timescale 1ns/1ps
module tb_lsu_subword_align;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_store, req_unsigned, big_endian;
  logic [1:0]  req_size;
  logic [31:0] base_val, store_val, mem_rdata;
  logic [15:0] offset;
  logic        mem_req, mem_we, misalign, ld_valid;
  logic [31:0] mem_addr, mem_wdata, ld_data;
  logic [3:0]  mem_be;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] ram [16];
  bit          pend_v = 0;
  logic [31:0] pend_d = '0;

  always #2.5 clk = ~clk;

  lsu_subword_align dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_unsigned(req_unsigned), .big_endian(big_endian),
    .base_val(base_val), .offset(offset), .store_val(store_val),
    .mem_rdata(mem_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .misalign(misalign), .ld_valid(ld_valid), .ld_data(ld_data)
  );

  // single-cycle word RAM
  always @(posedge clk) begin
    if (mem_req && mem_we) begin
      for (int k = 0; k < 4; k++)
        if (mem_be[k]) ram[mem_addr[5:2]][k*8 +: 8] <= mem_wdata[k*8 +: 8];
    end else if (mem_req) begin
      mem_rdata <= ram[mem_addr[5:2]];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int lane_of(input logic [1:0] a, input bit bem);
    return bem ? 3 - int'(a) : int'(a);
  endfunction

  // one clock: drive at negedge, compare 1 ns later
  task automatic step(input bit v, input bit st, input logic [1:0] sz, input bit uns,
                      input bit bem, input logic [31:0] b, input logic [15:0] off,
                      input logic [31:0] sv);
    logic [31:0] ea, e_wd, e_ld, w;
    logic [3:0]  e_be;
    int          n;
    bit          bad;
    @(negedge clk);
    req_valid = v; req_store = st; req_size = sz; req_unsigned = uns;
    big_endian = bem; base_val = b; offset = off; store_val = sv;
    #1;
    ea  = b + {{16{off[15]}}, off};
    n   = sz[1] ? 4 : (sz[0] ? 2 : 1);
    bad = v && ((n == 2 && ea[0]) || (n == 4 && ea[1:0] != 2'b00));
    // load response from previous request (R7, R11)
    chk(ld_valid == pend_v, "R7 ld_valid", {31'b0, ld_valid}, {31'b0, pend_v});
    if (pend_v)
      chk(ld_data == pend_d, sz_tag(), ld_data, pend_d);
    chk(misalign == bad, "R2 misalign", {31'b0, misalign}, {31'b0, bad});
    chk(mem_req == (v && !bad), "R3 mem_req", {31'b0, mem_req}, {31'b0, v && !bad});
    if (v) chk(mem_addr == {ea[31:2], 2'b00}, "R1 mem_addr", mem_addr, {ea[31:2], 2'b00});
    e_be = '0;
    if (v && st && !bad)
      for (int i = 0; i < n; i++) begin
        logic [31:0] ai;
        ai = ea + i;
        e_be[lane_of(ai[1:0], bem)] = 1'b1;
      end
    chk(mem_be == e_be, bem ? "R5 mem_be" : "R4 mem_be", {28'b0, mem_be}, {28'b0, e_be});
    chk(mem_we == (v && st && !bad), "R6 mem_we", {31'b0, mem_we}, {31'b0, v && st && !bad});
    if (v && st && !bad) begin
      e_wd = (n == 1) ? {4{sv[7:0]}} : (n == 2) ? {2{sv[15:0]}} : sv;
      chk(mem_wdata == e_wd, "R6 mem_wdata", mem_wdata, e_wd);
    end
    // expected value of this load, built byte by byte from addresses
    pend_v = v && !st && !bad;
    if (pend_v) begin
      w = ram[ea[5:2]];
      e_ld = '0;
      for (int i = 0; i < n; i++) begin
        logic [31:0] ai;
        int vb;
        ai = ea + i;
        vb = bem ? (n - 1 - i) : i;
        e_ld[vb*8 +: 8] = w[lane_of(ai[1:0], bem)*8 +: 8];
      end
      if (n == 1 && !uns) e_ld = {{24{e_ld[7]}}, e_ld[7:0]};
      if (n == 2 && !uns) e_ld = {{16{e_ld[15]}}, e_ld[15:0]};
      pend_d = e_ld;
      last_n = n;
    end
  endtask

  int last_n = 4;
  function automatic string sz_tag();
    return last_n == 1 ? "R8 byte load" : last_n == 2 ? "R9 half load" : "R10 word load";
  endfunction

  task automatic idle();
    step(0, 0, 2'b10, 0, 0, 32'h0, 16'h0, 32'h0);
  endtask

  initial begin
    logic [31:0] lfsr;
    for (int i = 0; i < 16; i++) ram[i] = 32'h0;
    mem_rdata = '0;
    rst_n = 1'b0;
    req_valid = 0; req_store = 0; req_size = 0; req_unsigned = 0;
    big_endian = 0; base_val = 0; offset = 0; store_val = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(ld_valid == 1'b0, "R7 reset ld_valid", {31'b0, ld_valid}, 32'h0);
    chk(mem_req == 1'b0, "R3 reset mem_req", {31'b0, mem_req}, 32'h0);
    rst_n = 1'b1;
    idle();

    // little-endian stores (R1 negative offset, R4, R6)
    step(1, 1, 2'b10, 0, 0, 32'h20, 16'hFFF0, 32'h8899AABB);
    step(1, 1, 2'b00, 0, 0, 32'h20, 16'h0001, 32'h000000F3);
    step(1, 1, 2'b01, 0, 0, 32'h20, 16'h0006, 32'h00008001);
    step(1, 1, 2'b00, 0, 0, 32'h13, 16'h0000, 32'h0000007E);
    // loads back to back, all flavours (R8, R9, R10)
    step(1, 0, 2'b00, 0, 0, 32'h21, 16'h0000, 32'h0);
    step(1, 0, 2'b00, 1, 0, 32'h21, 16'h0000, 32'h0);
    step(1, 0, 2'b01, 0, 0, 32'h26, 16'h0000, 32'h0);
    step(1, 0, 2'b01, 1, 0, 32'h26, 16'h0000, 32'h0);
    step(1, 0, 2'b10, 1, 0, 32'h10, 16'h0000, 32'h0);
    step(1, 0, 2'b00, 1, 0, 32'h13, 16'h0000, 32'h0);
    // big-endian (R5, R9, R11)
    step(1, 1, 2'b10, 0, 1, 32'h30, 16'h0000, 32'h11223384);
    step(1, 0, 2'b00, 0, 1, 32'h30, 16'h0000, 32'h0);
    step(1, 0, 2'b00, 0, 1, 32'h33, 16'h0000, 32'h0);
    step(1, 0, 2'b01, 0, 1, 32'h32, 16'h0000, 32'h0);
    step(1, 1, 2'b01, 0, 1, 32'h30, 16'h0000, 32'h0000C0DE);
    step(1, 1, 2'b00, 0, 1, 32'h31, 16'h0000, 32'h000000A5);
    step(1, 0, 2'b10, 0, 1, 32'h30, 16'h0000, 32'h0);
    step(1, 0, 2'b01, 0, 0, 32'h30, 16'h0000, 32'h0);
    step(1, 0, 2'b01, 1, 1, 32'h30, 16'h0000, 32'h0);
    // misaligned right after loads (R2, R3)
    step(1, 0, 2'b01, 0, 0, 32'h31, 16'h0000, 32'h0);
    step(1, 0, 2'b10, 0, 0, 32'h30, 16'h0002, 32'h0);
    step(1, 0, 2'b10, 0, 1, 32'h34, 16'h0000, 32'h0);
    step(1, 1, 2'b10, 0, 0, 32'h35, 16'h0000, 32'hDEADBEEF);
    step(1, 1, 2'b01, 0, 1, 32'h23, 16'h0000, 32'h1234);
    step(1, 0, 2'b10, 0, 0, 32'h34, 16'h0000, 32'h0);
    step(1, 0, 2'b10, 0, 0, 32'h20, 16'h0000, 32'h0);

    lfsr = 32'h1ACE5EED;
    for (int it = 0; it < 400; it++) begin
      logic [31:0] r;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      r = lfsr * 32'h9E3779B1;
      step(r[0] | r[1], r[2], r[4:3], r[5], r[6], {26'b0, r[12:7]},
           {{12{r[13]}}, r[17:14]}, {r[31:18], r[17:0]});
    end
    idle();
    idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule